// File: doc/BRIEF.md
# Open-Drain Clock/Data Pin-Pair Control Register

This block is a single 32-bit control register that owns one clock pad and one data pad, so that software can run a two-wire serial bus by toggling the pins directly. Each pin carries a direction bit and an output-value bit. Each of those two bits has its own write-enable (mask) bit in the same word. A write changes a field only when its mask bit is set in that write, so software can flip one pin's direction without first reading back the other fields.

The pads are open-drain by usage. Software produces a logic high by making the pin an input, which leaves the line to the board pull-up. It produces a low by making the pin an output that drives zero. The present level of each pad passes through a two-flop synchronizer and is visible in a read-only bit of the register. Two pull-up disable bits sit in the same word. Every write loads them, whatever the mask bits say.

Top module: `gpio_pinpair_reg`

## Requirements
- R1: After reset both pins are inputs (direction 0), both output values are 0 and both pull-up disable bits are 0. While reset is held the read word is 0. Once reset is released, the input bits read 1 for released lines after two clock edges.
- R2: Pin p (p=0 clock, p=1 data) uses bit 8p as its direction mask and bit 8p+1 as its direction (1 = output). A write changes the direction only when the direction mask is 1.
- R3: Bit 8p+2 is the value mask and bit 8p+3 is the output value. A write changes the value only when the value mask is 1.
- R4: A pin whose direction is 0 does not drive its pad. The line then rests at the external pull-up level. A release write that sets only the direction mask leaves the stored value unchanged.
- R5: A pin whose direction is 1 and whose value is 0 pulls its pad low. The pad changes right after the clock edge that takes the write.
- R6: Bit 8p+4 reads the pad level that was present two rising edges earlier, through a two-flop synchronizer. This includes a level forced low by an external device on a released line.
- R7: Bits 16 (clock) and 17 (data) are pull-up disable bits. Every write loads them from the written word, regardless of mask bits, and they read back as stored.
- R8: A write with all four mask bits of a pin at 0 leaves that pin's direction and value unchanged.
- R9: Mask bits, input bits on write, and all bits not named above have no stored effect. Mask bits and unnamed bits read as 0.
- R10: A pin's masks affect only that pin. The other pin's direction and value are untouched by them.
- R11: A pin whose direction is 1 and whose value is 1 drives its pad high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; the word is taken at the rising edge |
| wr_data | input | 32 | Written word with mask, direction, value and pull-up bits |
| rd_data | output | 32 | Current register contents with the synchronized pad levels |
| scl_pad | inout | 1 | Clock pad, driven only while its direction is output |
| sda_pad | inout | 1 | Data pad, driven only while its direction is output |

## Verification
A write that releases or grounds a pin and the synchronizer sampling that pad can land on the same edge. In the same way, an outside device can pull a released line low on the very edge where software turns the pin into an output. The bench provokes this by changing the external pull-down and issuing a register write in the same cycle. It then judges the input bit one edge and two edges later against a bench model of the line level: released lines follow the external device, and driven lines follow their value. A near-exhaustive sweep covers every prior direction/value state against every combination of the four per-pin control bits, and the result is checked both at the pad and at the read port.

// File: rtl/gpio_pp_pkg.sv
package gpio_pp_pkg;

  localparam int NUM_PINS   = 2;
  localparam int WORD_W     = 32;
  localparam int PIN_STRIDE = 8;
  localparam int OFS_DMSK   = 0;
  localparam int OFS_DIR    = 1;
  localparam int OFS_VMSK   = 2;
  localparam int OFS_VAL    = 3;
  localparam int OFS_IN     = 4;
  localparam int PU_BASE    = 16;

  typedef struct packed {
    logic dmsk;
    logic dir;
    logic vmsk;
    logic val;
  } pin_ctl_t;

  // absolute bit index of a per-pin field
  function automatic int fld(input int pin, input int ofs);
    return pin * PIN_STRIDE + ofs;
  endfunction

  // masked field merge
  function automatic logic take(input logic old_v, input logic msk, input logic new_v);
    return msk ? new_v : old_v;
  endfunction

  // slice the per-pin control bits out of a written word
  function automatic pin_ctl_t ctl_of(input logic [WORD_W-1:0] w, input int pin);
    pin_ctl_t c;
    c.dmsk = w[fld(pin, OFS_DMSK)];
    c.dir  = w[fld(pin, OFS_DIR)];
    c.vmsk = w[fld(pin, OFS_VMSK)];
    c.val  = w[fld(pin, OFS_VAL)];
    return c;
  endfunction

  // assemble the read word; mask and unnamed bits read 0
  function automatic logic [WORD_W-1:0] pack_word(
      input logic [NUM_PINS-1:0] dir,
      input logic [NUM_PINS-1:0] val,
      input logic [NUM_PINS-1:0] inb,
      input logic [NUM_PINS-1:0] pu);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      w[fld(p, OFS_DIR)] = dir[p];
      w[fld(p, OFS_VAL)] = val[p];
      w[fld(p, OFS_IN)]  = inb[p];
      w[PU_BASE + p]     = pu[p];
    end
    return w;
  endfunction

endpackage

// File: rtl/gpio_pp_pin_field.sv
module gpio_pp_pin_field
  import gpio_pp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pin_ctl_t ctl,
  output logic     dir_q,
  output logic     val_q,
  output logic     dir_ld,
  output logic     val_ld
);

  logic dir_d;
  logic val_d;

  assign dir_ld = wr_en & ctl.dmsk;
  assign val_ld = wr_en & ctl.vmsk;
  assign dir_d  = take(dir_q, dir_ld, ctl.dir);
  assign val_d  = take(val_q, val_ld, ctl.val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      val_q <= val_d;
    end
  end

endmodule

// File: rtl/gpio_pp_sync.sv
module gpio_pp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pinpair_reg.sv
module gpio_pinpair_reg
  import gpio_pp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  inout  wire               scl_pad,
  inout  wire               sda_pad
);

  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] val_q;
  logic [NUM_PINS-1:0] dir_ld;
  logic [NUM_PINS-1:0] val_ld;
  logic [NUM_PINS-1:0] pad_oe;
  logic [NUM_PINS-1:0] pad_lvl;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] pu_q;
  logic                unused_wr_bits;

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_pp_pin_field u_fld (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .ctl    (ctl_of(wr_data, p)),
        .dir_q  (dir_q[p]),
        .val_q  (val_q[p]),
        .dir_ld (dir_ld[p]),
        .val_ld (val_ld[p])
      );

      gpio_pp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_lvl[p]),
        .q     (in_sync[p])
      );
    end
  endgenerate

  // pull-up disable bits load on every write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pu_q <= '0;
    else if (wr_en) pu_q <= wr_data[PU_BASE +: NUM_PINS];
  end

  assign pad_oe  = dir_q;
  assign scl_pad = pad_oe[0] ? val_q[0] : 1'bz;
  assign sda_pad = pad_oe[1] ? val_q[1] : 1'bz;
  assign pad_lvl = {sda_pad, scl_pad};

  assign rd_data = pack_word(dir_q, val_q, in_sync, pu_q);

  assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/gpio_pinpair_reg_chk.sv
module gpio_pinpair_reg_chk
  import gpio_pp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [WORD_W-1:0]   wr_data,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] val_q,
  input logic [NUM_PINS-1:0] pu_q,
  input logic [NUM_PINS-1:0] pad_lvl,
  input logic [NUM_PINS-1:0] in_sync
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_PU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pu_q == $past(wr_data[PU_BASE +: NUM_PINS])); // R7

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
      AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[p*PIN_STRIDE+OFS_DMSK]) |=> dir_q[p] == $past(wr_data[p*PIN_STRIDE+OFS_DIR])); // R2
      AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[p*PIN_STRIDE+OFS_DMSK]) |=> $stable(dir_q[p])); // R8
      AST_VAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[p*PIN_STRIDE+OFS_VMSK]) |=> val_q[p] == $past(wr_data[p*PIN_STRIDE+OFS_VAL])); // R3
      AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[p*PIN_STRIDE+OFS_VMSK]) |=> $stable(val_q[p])); // R4
      AST_DRIVEN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        dir_q[p] |-> pad_lvl[p] == val_q[p]); // R5
      if (SYNC_STAGES == 2) begin : g_s2
        AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
          (since_rst == 2'd2) |-> in_sync[p] == $past(pad_lvl[p], 2)); // R6
      end
    end
  endgenerate

endmodule

bind gpio_pinpair_reg gpio_pinpair_reg_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .dir_q   (dir_q),
  .val_q   (val_q),
  .pu_q    (pu_q),
  .pad_lvl (pad_lvl),
  .in_sync (in_sync)
);

// File: tb/gpio_pinpair_reg_tb.sv
module gpio_pinpair_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  wire         scl_net;
  wire         sda_net;
  logic [1:0]  ext_low;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench model
  logic [1:0] mdir, mval, mpu;

  always #10 clk = ~clk;

  pullup (scl_net);
  pullup (sda_net);
  assign scl_net = ext_low[0] ? 1'b0 : 1'bz;
  assign sda_net = ext_low[1] ? 1'b0 : 1'bz;

  gpio_pinpair_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .scl_pad(scl_net), .sda_pad(sda_net)
  );

  function automatic logic line(input int p);
    if (mdir[p]) return mval[p];
    return !ext_low[p];
  endfunction

  // read word from requirements: dir at 8p+1, val at 8p+3, input at 8p+4, pull-up at 16+p
  function automatic logic [31:0] expect_word();
    logic [31:0] w = 32'h0;
    for (int p = 0; p < 2; p++) begin
      w = w | ({31'h0, mdir[p]} << (8*p+1)) | ({31'h0, mval[p]} << (8*p+3))
            | ({31'h0, line(p)} << (8*p+4)) | ({31'h0, mpu[p]} << (16+p));
    end
    return w;
  endfunction

  task automatic model_write(input logic [31:0] w);
    for (int p = 0; p < 2; p++) begin
      if (w[8*p])   mdir[p] = w[8*p+1];
      if (w[8*p+2]) mval[p] = w[8*p+3];
    end
    mpu = w[17:16];
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(posedge clk);
    model_write(w);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 32'hA5A5_0000 ^ w; // noise, not written
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ext_low = 2'b00;
    mdir = '0; mval = '0; mpu = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 word during reset", rd_data, 32'h0);
    rst_n = 1'b1;
    chk("R1 word at release", rd_data, 32'h0);
    settle();
    chk("R1 inputs high after sync", rd_data, expect_word());
    chk("R1 exact reset word", rd_data, 32'h0000_1010);

    // sweep: pin, prior state, all 16 control nibbles
    for (int p = 0; p < 2; p++) begin
      for (int prior = 0; prior < 4; prior++) begin
        for (int nib = 0; nib < 16; nib++) begin
          logic [31:0] w0, w1;
          logic [1:0]  odir, oval;
          w0 = ({30'h0, 2'(prior >> 1)} << (8*p+1)) | (32'h1 << (8*p)) |
               (32'h4 << (8*p)) | ({31'h0, prior[0]} << (8*p+3)) |
               ({30'h0, 2'(nib)} << 16);
          do_write(w0);
          odir = mdir; oval = mval;
          // nib bit3=dir mask, bit2=dir, bit1=value mask, bit0=value; junk in input/unused bits
          w1 = ({31'h0, nib[3]} << (8*p)) | ({31'h0, nib[2]} << (8*p+1)) |
               ({31'h0, nib[1]} << (8*p+2)) | ({31'h0, nib[0]} << (8*p+3)) |
               (32'h10 << (8*p)) | 32'h8040_0000 | ({30'h0, 2'(prior)} << 16);
          do_write(w1);
          if (p == 0) chk("R4/R5/R11 clock pad level", {31'h0, scl_net}, {31'h0, line(0)});
          else        chk("R4/R5/R11 data pad level", {31'h0, sda_net}, {31'h0, line(1)});
          chk("R10 other pin untouched", {30'h0, mdir[1-p], mval[1-p]}, {30'h0, odir[1-p], oval[1-p]});
          settle();
          if (nib[3] == 0 && nib[1] == 0)
            chk("R8 maskless write keeps pin", rd_data, expect_word());
          else
            chk("R2/R3/R7/R9/R6 swept word", rd_data, expect_word());
        end
      end
    end

    // R6: external pull-down on a released line, latency of two edges
    do_write(32'h0000_0505); // both released, values 0
    settle();
    chk("R4 released lines high", rd_data, expect_word());
    @(negedge clk);
    ext_low = 2'b01;
    @(posedge clk); @(negedge clk);
    chk("R6 clock input still old after one edge", {31'h0, rd_data[4]}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R6 clock input low after two edges", {31'h0, rd_data[4]}, 32'h0);
    chk("R6 data input unaffected", {31'h0, rd_data[12]}, 32'h1);

    // same-cycle: external device lets go of clock while data is grounded by a write
    @(negedge clk);
    ext_low = 2'b00;
    wr_en = 1'b1; wr_data = 32'h0000_0300; // data dir mask + dir output, value stays 0
    @(posedge clk);
    model_write(32'h0000_0300);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 data pad low right after write edge", {31'h0, sda_net}, 32'h0);
    settle();
    chk("R6 same-cycle release and ground", rd_data, expect_word());

    // R4: release leaves value field
    do_write(32'h0000_0F00); // data output high
    chk("R11 data driven high", {31'h0, sda_net}, 32'h1);
    do_write(32'h0000_0100); // release data, value untouched
    settle();
    chk("R4 release keeps value bit", {31'h0, rd_data[11]}, 32'h1);
    chk("R4 release word", rd_data, expect_word());

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule